// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block keeps a word of pending interrupt causes and a word of enable bits, and drives one level-sensitive interrupt line. Software reaches it through four write strobes, each with its own data word: one sets causes, one clears causes, one sets enables and one clears enables. It also has a read strobe. A read returns the cause word and empties it in the same access. Logic elsewhere in the chip raises cause bits through a hardware event vector, and it may do so in the same cycle as any software access.

The top cause bit is not stored. It is a summary flag that the block computes from the other cause bits, and it reads as 1 whenever at least one of them is pending. The interrupt line is the OR of the enabled causes. By default it is registered, so it follows the state change by one clock.

Top module: `icm_intr_ctrl`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the enable word and the full cause word (summary bit included) is nonzero.
- R2: With the default registered output mode, `irq` reflects the cause and enable state one clock after that state changes.
- R3: A strobe on `cause_set_we` ORs `cause_set_val` into cause bits [CAUSE_W-2:0], and the other bits keep their value.
- R4: A strobe on `cause_clr_we` clears every cause bit whose bit in `cause_clr_val` is 1, and the bits written as 0 keep their value.
- R5: `mask_set_we` ORs `mask_set_val` into the enable word. `mask_clr_we` clears the enable bits written as 1. If both strike in one cycle, the set is applied last and wins.
- R6: `cause_rd_data` shows the current cause word, including in the cycle of a read. A strobe on `cause_rd_en` empties the cause word at the next edge, apart from causes that are raised in that same cycle.
- R7: Cause bit CAUSE_W-1 reads as 1 exactly when any of bits [CAUSE_W-2:0] is 1, and it returns to 0 once they are all clear.
- R8: A cause bit raised in a cycle, whether by `hw_event` or by `cause_set_we`, is set after that edge even if a clear or a read hits the same bit in the same cycle.
- R9: After reset, the cause word and the enable word are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_set_we | input | 1 | Set-cause strobe |
| cause_set_val | input | CAUSE_W-1 | Cause bits to raise |
| cause_clr_we | input | 1 | Clear-cause strobe |
| cause_clr_val | input | CAUSE_W-1 | Cause bits to drop (1 = clear) |
| mask_set_we | input | 1 | Set-enable strobe |
| mask_set_val | input | CAUSE_W | Enable bits to raise |
| mask_clr_we | input | 1 | Clear-enable strobe |
| mask_clr_val | input | CAUSE_W | Enable bits to drop (1 = clear) |
| cause_rd_en | input | 1 | Read strobe; empties the cause word |
| cause_rd_data | output | CAUSE_W | Current cause word with summary bit |
| hw_event | input | CAUSE_W-1 | Hardware cause requests, one per bit |
| irq | output | 1 | Level interrupt request |

## Verification
The cause and enable words are driven one operation at a time through a sequence of accumulating vectors. These vectors separate OR-in from write-1-to-clear, and they show that the summary bit tracks the lower bits in both directions. Further vectors put pairs of operations in a single cycle: set with clear, event with clear, event with read, and enable set with enable clear. These pin down which one takes priority. The interrupt line is sampled once in the cycle right after each cause change and once a cycle later. This tells a registered output apart from a combinational one, and a masked cause apart from an enabled one.

// File: rtl/icm_pkg.sv
package icm_pkg;

   // How the interrupt line is produced from the cause and enable state.
   typedef enum logic {
      IRQ_COMB = 1'b0,
      IRQ_REG  = 1'b1
   } irq_mode_e;

   localparam int unsigned ICM_MIN_W = 2;
   localparam int unsigned ICM_MAX_W = 64;

endpackage

// File: rtl/icm_cause_reg.sv
module icm_cause_reg #(
   parameter int unsigned CAUSE_W = 32,
   localparam int unsigned LOW_W  = CAUSE_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic [LOW_W-1:0]   set_val,
   input  logic               clr_we,
   input  logic [LOW_W-1:0]   clr_val,
   input  logic               rd_en,
   input  logic [LOW_W-1:0]   event_in,
   output logic [CAUSE_W-1:0] cause
);

   logic [LOW_W-1:0] low_q;
   logic [LOW_W-1:0] low_nxt;

   // Operations apply in order: read-empty, clear, set, event.
   // Whatever comes later takes priority.
   always_comb begin
      low_nxt = low_q;
      if (rd_en)  low_nxt = '0;
      if (clr_we) low_nxt = low_nxt & ~clr_val;
      if (set_we) low_nxt = low_nxt | set_val;
      low_nxt = low_nxt | event_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) low_q <= '0;
      else        low_q <= low_nxt;
   end

   // The summary bit is computed, never stored.
   assign cause = {|low_q, low_q};

endmodule

// File: rtl/icm_mask_reg.sv
module icm_mask_reg #(
   parameter int unsigned CAUSE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic [CAUSE_W-1:0] set_val,
   input  logic               clr_we,
   input  logic [CAUSE_W-1:0] clr_val,
   output logic [CAUSE_W-1:0] mask
);

   logic [CAUSE_W-1:0] mask_q;
   logic [CAUSE_W-1:0] mask_nxt;

   always_comb begin
      mask_nxt = mask_q;
      if (clr_we) mask_nxt = mask_nxt & ~clr_val;
      if (set_we) mask_nxt = mask_nxt | set_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt;
   end

   assign mask = mask_q;

endmodule

// File: rtl/icm_irq_out.sv
module icm_irq_out #(
   parameter int unsigned      CAUSE_W  = 32,
   parameter icm_pkg::irq_mode_e IRQ_MODE = icm_pkg::IRQ_REG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] cause,
   input  logic [CAUSE_W-1:0] mask,
   output logic               irq
);

   logic hit;
   assign hit = |(cause & mask);

   generate
      if (IRQ_MODE == icm_pkg::IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk & rst_n;
         assign irq = hit;
      end
   endgenerate

endmodule

// File: rtl/icm_intr_ctrl.sv
module icm_intr_ctrl #(
   parameter int unsigned        CAUSE_W  = 32,
   parameter icm_pkg::irq_mode_e IRQ_MODE = icm_pkg::IRQ_REG,
   localparam int unsigned       LOW_W    = CAUSE_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cause_set_we,
   input  logic [LOW_W-1:0]   cause_set_val,
   input  logic               cause_clr_we,
   input  logic [LOW_W-1:0]   cause_clr_val,
   input  logic               mask_set_we,
   input  logic [CAUSE_W-1:0] mask_set_val,
   input  logic               mask_clr_we,
   input  logic [CAUSE_W-1:0] mask_clr_val,
   input  logic               cause_rd_en,
   output logic [CAUSE_W-1:0] cause_rd_data,
   input  logic [LOW_W-1:0]   hw_event,
   output logic               irq
);

   generate
      if (CAUSE_W < icm_pkg::ICM_MIN_W || CAUSE_W > icm_pkg::ICM_MAX_W) begin : g_bad_width
         $error("icm_intr_ctrl: CAUSE_W out of range");
      end
   endgenerate

   logic [CAUSE_W-1:0] cause_q;
   logic [CAUSE_W-1:0] mask_q;

   icm_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (cause_set_we),
      .set_val  (cause_set_val),
      .clr_we   (cause_clr_we),
      .clr_val  (cause_clr_val),
      .rd_en    (cause_rd_en),
      .event_in (hw_event),
      .cause    (cause_q)
   );

   icm_mask_reg #(.CAUSE_W(CAUSE_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (mask_set_we),
      .set_val (mask_set_val),
      .clr_we  (mask_clr_we),
      .clr_val (mask_clr_val),
      .mask    (mask_q)
   );

   icm_irq_out #(.CAUSE_W(CAUSE_W), .IRQ_MODE(IRQ_MODE)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cause (cause_q),
      .mask  (mask_q),
      .irq   (irq)
   );

   assign cause_rd_data = cause_q;

endmodule

// File: rtl/icm_intr_ctrl_chk.sv
module icm_intr_ctrl_chk #(
   parameter int unsigned        CAUSE_W  = 32,
   parameter icm_pkg::irq_mode_e IRQ_MODE = icm_pkg::IRQ_REG,
   localparam int unsigned       LOW_W    = CAUSE_W - 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cause_set_we,
   input logic [LOW_W-1:0]   cause_set_val,
   input logic               cause_clr_we,
   input logic [LOW_W-1:0]   cause_clr_val,
   input logic               mask_set_we,
   input logic [CAUSE_W-1:0] mask_set_val,
   input logic               cause_rd_en,
   input logic [LOW_W-1:0]   hw_event,
   input logic [CAUSE_W-1:0] cause,
   input logic [CAUSE_W-1:0] mask,
   input logic               irq
);

   // R7: the summary bit tracks the lower cause bits
   assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cause[CAUSE_W-1] == (|cause[LOW_W-1:0]));

   // R6: a read with nothing raised leaves the cause word empty
   assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd_en && !cause_set_we && hw_event == '0) |=> cause == '0);

   // R4: cleared bits are gone when nothing else touches the word
   assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_clr_we && !cause_set_we && !cause_rd_en && hw_event == '0)
      |=> (cause[LOW_W-1:0] & $past(cause_clr_val)) == '0);

   // R8: an event bit is present after its edge, whatever else happened
   assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_event != '0) |=> (cause[LOW_W-1:0] & $past(hw_event)) == $past(hw_event));

   // R3: a set strobe lands its bits
   assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cause_set_we |=> (cause[LOW_W-1:0] & $past(cause_set_val)) == $past(cause_set_val));

   // R5: enable set wins over a simultaneous clear
   assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set_we |=> (mask & $past(mask_set_val)) == $past(mask_set_val));

   generate
      if (IRQ_MODE == icm_pkg::IRQ_REG) begin : g_reg_chk
         // R2: the line follows the state of the previous cycle
         assert_irq_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(|(cause & mask)));
      end else begin : g_comb_chk
         // R1: the line equals the enabled-cause OR
         always_comb begin
            if (rst_n) assert_irq_level_R1: assert (irq == |(cause & mask));
         end
      end
   endgenerate

endmodule

bind icm_intr_ctrl icm_intr_ctrl_chk #(.CAUSE_W(CAUSE_W), .IRQ_MODE(IRQ_MODE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cause_set_we  (cause_set_we),
   .cause_set_val (cause_set_val),
   .cause_clr_we  (cause_clr_we),
   .cause_clr_val (cause_clr_val),
   .mask_set_we   (mask_set_we),
   .mask_set_val  (mask_set_val),
   .cause_rd_en   (cause_rd_en),
   .hw_event      (hw_event),
   .cause         (cause_q),
   .mask          (mask_q),
   .irq           (irq)
);

// File: tb/tb_icm_intr_ctrl.sv
module tb_icm_intr_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_we = 0, cc_we = 0, ms_we = 0, mc_we = 0, rd_en = 0;
   logic [W-2:0]  cs_val = '0, cc_val = '0, ev = '0;
   logic [W-1:0]  ms_val = '0, mc_val = '0;
   logic [W-1:0]  rd_data;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   icm_intr_ctrl #(.CAUSE_W(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .cause_set_we(cs_we), .cause_set_val(cs_val),
      .cause_clr_we(cc_we), .cause_clr_val(cc_val),
      .mask_set_we(ms_we), .mask_set_val(ms_val),
      .mask_clr_we(mc_we), .mask_clr_val(mc_val),
      .cause_rd_en(rd_en), .cause_rd_data(rd_data),
      .hw_event(ev), .irq(irq)
   );

   typedef struct packed {
      logic          sc_we;
      logic [W-2:0]  sc;
      logic          cc_we;
      logic [W-2:0]  cc;
      logic          sm_we;
      logic [W-1:0]  sm;
      logic          cm_we;
      logic [W-1:0]  cm;
      logic          rd;
      logic [W-2:0]  evv;
      logic [W-1:0]  exp_cause;
      logic          exp_irq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      // sc_we sc          cc_we cc          sm_we sm            cm_we cm            rd   ev          cause          irq
      '{1'b1, 31'h5,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h0,  32'h80000005, 1'b0}, // R3 R7
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b1, 32'h4,  1'b0, 32'h0,  1'b0, 31'h0,  32'h80000005, 1'b1}, // R1 R5
      '{1'b0, 31'h0,  1'b1, 31'h4,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h0,  32'h80000001, 1'b0}, // R4
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h10, 32'h80000011, 1'b0}, // R8 event
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b1, 32'h10, 1'b0, 32'h0,  1'b0, 31'h0,  32'h80000011, 1'b1}, // R1
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b1, 32'h10, 1'b0, 31'h0,  32'h80000011, 1'b0}, // R5 clear
      '{1'b0, 31'h0,  1'b1, 31'h11, 1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h0,  32'h00000000, 1'b0}, // R7 drop
      '{1'b1, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h0,  32'h00000000, 1'b0}, // R7 empty set
      '{1'b1, 31'h4,  1'b1, 31'h4,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h0,  32'h80000004, 1'b1}, // R8 set vs clr
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b1, 31'h0,  32'h00000000, 1'b0}, // R6
      '{1'b0, 31'h0,  1'b1, 31'h4,  1'b0, 32'h0,  1'b0, 32'h0,  1'b0, 31'h4,  32'h80000004, 1'b1}, // R8 ev vs clr
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b1, 31'h2,  32'h80000002, 1'b0}, // R8 ev vs rd
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b1, 32'h2,  1'b1, 32'h2,  1'b0, 31'h0,  32'h80000002, 1'b1}, // R5 set vs clr
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b1, 32'hFFFFFFFF, 1'b0, 31'h0, 32'h80000002, 1'b0}, // R5 all off
      '{1'b0, 31'h0,  1'b0, 31'h0,  1'b0, 32'h0,  1'b0, 32'h0,  1'b1, 31'h0,  32'h00000000, 1'b0}  // R6
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cs_we = 0; cc_we = 0; ms_we = 0; mc_we = 0; rd_en = 0;
      cs_val = '0; cc_val = '0; ms_val = '0; mc_val = '0; ev = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk("R9 cause", rd_data, '0);
      chk("R9 irq", {31'b0, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cs_we = VEC[i].sc_we; cs_val = VEC[i].sc;
         cc_we = VEC[i].cc_we; cc_val = VEC[i].cc;
         ms_we = VEC[i].sm_we; ms_val = VEC[i].sm;
         mc_we = VEC[i].cm_we; mc_val = VEC[i].cm;
         rd_en = VEC[i].rd;    ev = VEC[i].evv;
         @(negedge clk);
         idle_inputs();
         chk($sformatf("R3/R4/R6/R7/R8 vec %0d cause", i), rd_data, VEC[i].exp_cause);
         @(negedge clk);
         chk($sformatf("R1/R5 vec %0d irq", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
      end

      // R6: read returns the live value in its own cycle
      @(negedge clk);
      cs_we = 1; cs_val = 31'h3;
      @(negedge clk);
      idle_inputs();
      rd_en = 1;
      chk("R6 value during read", rd_data, 32'h80000003);
      @(negedge clk);
      idle_inputs();
      chk("R6 empty after read", rd_data, 32'h0);

      // R2: one clock of latency on the interrupt line
      @(negedge clk);
      mc_we = 1; mc_val = '1;
      @(negedge clk);
      idle_inputs();
      ms_we = 1; ms_val = 32'h1;
      cs_we = 1; cs_val = 31'h1;
      @(negedge clk);
      idle_inputs();
      chk("R2 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R2 irq one clock later", {31'b0, irq}, 32'h1);

      // R9: reset from a busy state
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R9 cause after reset", rd_data, 32'h0);
      chk("R9 irq after reset", {31'b0, irq}, 32'h0);
      // R9: enable word is zero -> a new cause does not raise irq
      cs_we = 1; cs_val = 31'h1;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      chk("R9 mask zero after reset", {31'b0, irq}, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule